// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit. Software changes it in three ways: it sets one bit, clears one bit, or writes the whole word. The arithmetic datapath reports new exceptions by ORing them into the sticky exception bits. The block presents the current rounding mode to the datapath, and it raises an exception request while any enabled exception is pending.

The two summary flags, invalid-summary (VX) and enabled-exception-summary (FEX), are never kept in flops of their own. They are derived from the stored source bits. As a result they match those bits in every cycle. Clearing the last invalid-operation flag therefore drops VX and FEX together, in the cycle the clear takes effect.

Bits use big-endian numbering: architectural bit n sits at word position 31-n. A command's bit index is an architectural number.

Top module: `fpstat_ctl_reg`

## Requirements
- R1: After reset, rd_data is 0, round_mode is 0 and exc_req is 0.
- R2: A set or clear command on bit index n changes word position 31-n one cycle later. When several commands arrive in one cycle, a full write wins over a set, and a set wins over a clear.
- R3: VX (arch 2, position 29) reads as the OR of the invalid-operation flags. These are arch 7 to 12 (positions 24 to 19) and arch 21 to 23 (positions 10 to 8).
- R4: FEX (arch 1, position 30) reads as the OR of five pairs, each an exception flag ANDed with its enable. The pairs are VX with VE (arch 24), OX (arch 3) with OE (25), UX (4) with UE (26), ZX (5) with ZE (27), and XX (6) with XE (28).
- R5: Set and clear commands aimed at VX (arch 2), FEX (arch 1) or the reserved bit (arch 20, position 11) have no effect. The reserved position always reads 0.
- R6: A full write stores every other bit as supplied. The block ignores the supplied VX and FEX values and derives both from the newly written bits.
- R7: A datapath report ORs its mask into the exception flags: arch 3 to 12 and arch 21 to 23. All other mask bits are ignored. A software command in the same cycle is applied first, and the report is ORed in after it.
- R8: FX (arch 0, position 31) becomes 1 when a report or a set command takes any exception flag from 0 to 1. It does not change when the flag was already 1. Only a clear of FX or a full write lowers it.
- R9: round_mode equals the word's rounding field, arch 30 and 31 (positions 1 and 0), as {arch30, arch31}.
- R10: exc_req equals the FEX value presented on rd_data.
- R11: Clearing the last set invalid-operation flag drops VX and also drops FEX in the same cycle when VE was what enabled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Word to write |
| set_en | input | 1 | Set-one-bit command |
| clr_en | input | 1 | Clear-one-bit command |
| bit_idx | input | 5 | Architectural bit number for set and clear |
| rpt_en | input | 1 | Datapath exception report valid |
| rpt_mask | input | 32 | Exception flags reported, in word positions |
| rd_data | output | 32 | Current word, summaries included |
| round_mode | output | 2 | Rounding mode for the datapath |
| exc_req | output | 1 | Enabled exception pending |

## Verification
The properties assume that every input is a known value on each clock edge. They also assume bit_idx may name any of the 32 positions, including the derived and reserved ones. The random stimulus draws all control strobes from a seeded generator, so set, clear, write and report collide in the same cycle, and bit indices range over the full 0 to 31. Reports use sparse masks, which lets single flags rise one at a time, while occasional full writes load dense patterns that switch the summaries on and off.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
   localparam int FPSC_W = 32;

   // word positions (architectural bit n lives at 31-n)
   localparam int P_FX  = 31;
   localparam int P_FEX = 30;
   localparam int P_VX  = 29;
   localparam int P_OX  = 28;
   localparam int P_UX  = 27;
   localparam int P_ZX  = 26;
   localparam int P_XX  = 25;
   localparam int P_VE  = 7;
   localparam int P_OE  = 6;
   localparam int P_UE  = 5;
   localparam int P_ZE  = 4;
   localparam int P_XE  = 3;

   localparam logic [FPSC_W-1:0] M_INVALID = 32'h01F8_0700;
   localparam logic [FPSC_W-1:0] M_EXCEPT  = 32'h1FF8_0700;
   localparam logic [FPSC_W-1:0] M_DERIVED = 32'h6000_0000;
   localparam logic [FPSC_W-1:0] M_RSVD    = 32'h0000_0800;
   localparam logic [FPSC_W-1:0] M_STORE   = ~(M_DERIVED | M_RSVD);
   localparam logic [FPSC_W-1:0] M_ENABLES = 32'h0000_00F8;
endpackage

// File: rtl/fpsc_summary.sv
module fpsc_summary
   import fpsc_pkg::*;
#(
   parameter int WORD_W = FPSC_W
) (
   input  logic [WORD_W-1:0] word,
   output logic              vx,
   output logic              fex
);
   generate
      if (WORD_W != FPSC_W) begin : g_bad_w
         $error("fpsc_summary: WORD_W must be 32");
      end
   endgenerate

   logic [4:0] pair;

   always_comb begin
      vx      = |(word & M_INVALID);
      pair[0] = vx & word[P_VE];
      pair[1] = word[P_OX] & word[P_OE];
      pair[2] = word[P_UX] & word[P_UE];
      pair[3] = word[P_ZX] & word[P_ZE];
      pair[4] = word[P_XX] & word[P_XE];
      fex     = |pair;
   end
endmodule

// File: rtl/fpsc_cmd.sv
module fpsc_cmd
   import fpsc_pkg::*;
#(
   parameter int WORD_W = FPSC_W,
   localparam int IDX_W = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] cur,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  bit_idx,
   output logic [WORD_W-1:0] sw_word,
   output logic [WORD_W-1:0] set_rise
);
   generate
      if (WORD_W != FPSC_W) begin : g_bad_w
         $error("fpsc_cmd: WORD_W must be 32");
      end
   endgenerate

   logic do_set, do_clr;
   assign do_set = set_en & ~wr_en;
   assign do_clr = clr_en & ~set_en & ~wr_en;

   for (genvar p = 0; p < WORD_W; p++) begin : g_bit
      if (M_STORE[p]) begin : g_cell
         logic hit;
         assign hit = (bit_idx == IDX_W'(WORD_W - 1 - p));
         always_comb begin
            if (wr_en)               sw_word[p] = wr_data[p];
            else if (do_set && hit)  sw_word[p] = 1'b1;
            else if (do_clr && hit)  sw_word[p] = 1'b0;
            else                     sw_word[p] = cur[p];
         end
         if (M_EXCEPT[p]) begin : g_rise
            assign set_rise[p] = do_set & hit & ~cur[p];
         end else begin : g_norise
            assign set_rise[p] = 1'b0;
         end
      end else begin : g_fixed
         assign sw_word[p]  = 1'b0;
         assign set_rise[p] = 1'b0;
      end
   end
endmodule

// File: rtl/fpsc_merge.sv
module fpsc_merge
   import fpsc_pkg::*;
#(
   parameter int WORD_W    = FPSC_W,
   parameter bit REPORT_EN = 1'b1
) (
   input  logic [WORD_W-1:0] sw_word,
   input  logic [WORD_W-1:0] set_rise,
   input  logic              rpt_en,
   input  logic [WORD_W-1:0] rpt_mask,
   output logic [WORD_W-1:0] nxt_word
);
   logic [WORD_W-1:0] rpt_bits;

   generate
      if (WORD_W != FPSC_W) begin : g_bad_w
         $error("fpsc_merge: WORD_W must be 32");
      end
      if (REPORT_EN) begin : g_rpt
         assign rpt_bits = rpt_en ? (rpt_mask & M_EXCEPT) : '0;
      end else begin : g_norpt
         assign rpt_bits = '0;
      end
   endgenerate

   logic [WORD_W-1:0] merged;
   logic              any_rise;

   always_comb begin
      merged   = sw_word | rpt_bits;
      any_rise = |(rpt_bits & ~sw_word) | (|set_rise);
      nxt_word = merged;
      nxt_word[P_FX] = merged[P_FX] | any_rise;
   end
endmodule

// File: rtl/fpstat_ctl_reg.sv
module fpstat_ctl_reg
   import fpsc_pkg::*;
#(
   parameter int                 WORD_W     = FPSC_W,
   parameter logic [FPSC_W-1:0]  RESET_WORD = '0,
   parameter bit                 REPORT_EN  = 1'b1,
   localparam int                IDX_W      = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              rpt_en,
   input  logic [WORD_W-1:0] rpt_mask,
   output logic [WORD_W-1:0] rd_data,
   output logic [1:0]        round_mode,
   output logic              exc_req
);
   generate
      if (WORD_W != FPSC_W) begin : g_bad_w
         $error("fpstat_ctl_reg: WORD_W must be 32");
      end
      if ((RESET_WORD & ~M_STORE) != '0) begin : g_bad_rst
         $error("fpstat_ctl_reg: RESET_WORD sets derived or reserved bits");
      end
   endgenerate

   logic [WORD_W-1:0] state_q, sw_word, set_rise, nxt_word;
   logic              vx, fex;

   fpsc_cmd #(.WORD_W(WORD_W)) u_cmd (
      .cur      (state_q),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .set_en   (set_en),
      .clr_en   (clr_en),
      .bit_idx  (bit_idx),
      .sw_word  (sw_word),
      .set_rise (set_rise)
   );

   fpsc_merge #(.WORD_W(WORD_W), .REPORT_EN(REPORT_EN)) u_merge (
      .sw_word  (sw_word),
      .set_rise (set_rise),
      .rpt_en   (rpt_en),
      .rpt_mask (rpt_mask),
      .nxt_word (nxt_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= RESET_WORD;
      else        state_q <= nxt_word & M_STORE;
   end

   fpsc_summary #(.WORD_W(WORD_W)) u_sum (
      .word (state_q),
      .vx   (vx),
      .fex  (fex)
   );

   always_comb begin
      rd_data        = state_q & M_STORE;
      rd_data[P_VX]  = vx;
      rd_data[P_FEX] = fex;
   end
   assign round_mode = rd_data[1:0];
   assign exc_req    = fex;

   // R2: a set command (no write) lands at position 31-idx
   a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !wr_en && M_STORE[WORD_W-1-bit_idx]) |=>
         rd_data[WORD_W-1-$past(bit_idx)]);

   // R5: commands on derived or reserved bits leave the word as it was
   a_r5_derived_cmd_inert: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_en || clr_en) && !wr_en && !rpt_en && !M_STORE[WORD_W-1-bit_idx])
         |=> $stable(rd_data));

   // R6: full write without a report stores every storable bit as given
   a_r6_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rpt_en) |=>
         ((rd_data & M_STORE) == ($past(wr_data) & M_STORE)));

   // R7: reported exception flags are present next cycle
   a_r7_report_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_en |=> ((rd_data & $past(rpt_mask) & M_EXCEPT) ==
                  ($past(rpt_mask) & M_EXCEPT)));

   // R8: FX holds unless cleared or overwritten
   a_r8_fx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[P_FX] && !wr_en &&
       !(clr_en && !set_en && bit_idx == IDX_W'(0))) |=> rd_data[P_FX]);

   // R4/R10: with every enable low no request can be raised
   a_r4_no_enable_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data & M_ENABLES) == '0) |-> !exc_req);

   // R5: reserved position reads 0
   a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & M_RSVD) == '0);
endmodule

// File: tb/sim_fpstat_ctl_reg.sv
module sim_fpstat_ctl_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, set_en = 1'b0, clr_en = 1'b0, rpt_en = 1'b0;
   logic [31:0] wr_data = '0, rpt_mask = '0;
   logic [4:0]  bit_idx = '0;
   logic [31:0] rd_data;
   logic [1:0]  round_mode;
   logic        exc_req;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   logic [31:0] model = '0;

   always #10 clk = ~clk;

   fpstat_ctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .set_en(set_en), .clr_en(clr_en), .bit_idx(bit_idx),
      .rpt_en(rpt_en), .rpt_mask(rpt_mask),
      .rd_data(rd_data), .round_mode(round_mode), .exc_req(exc_req)
   );

   function automatic bit settable(int n);
      return (n != 1) && (n != 2) && (n != 20);
   endfunction

   function automatic bit is_exc(int n);
      return (n >= 3 && n <= 12) || (n >= 21 && n <= 23);
   endfunction

   function automatic logic [31:0] step_model(logic [31:0] cur, logic w,
         logic [31:0] wd, logic s, logic c, logic [4:0] ix, logic r,
         logic [31:0] rm);
      logic [31:0] nx;
      bit rise;
      int k;
      nx = cur;
      rise = 1'b0;
      k = int'(ix);
      if (w) begin
         for (int n = 0; n < 32; n++)
            nx[31-n] = settable(n) ? wd[31-n] : 1'b0;
      end else if (s) begin
         if (settable(k)) begin
            if (is_exc(k) && !cur[31-k]) rise = 1'b1;
            nx[31-k] = 1'b1;
         end
      end else if (c) begin
         if (settable(k)) nx[31-k] = 1'b0;
      end
      if (r) begin
         for (int n = 0; n < 32; n++)
            if (is_exc(n) && rm[31-n]) begin
               if (!nx[31-n]) rise = 1'b1;
               nx[31-n] = 1'b1;
            end
      end
      if (rise) nx[31] = 1'b1;
      return nx;
   endfunction

   function automatic logic [31:0] view(logic [31:0] st);
      logic [31:0] v;
      logic vx, fex;
      int inv[9] = '{7, 8, 9, 10, 11, 12, 21, 22, 23};
      v = st;
      vx = 1'b0;
      foreach (inv[i]) vx = vx | st[31-inv[i]];
      fex = (vx & st[31-24]) | (st[31-3] & st[31-25]) | (st[31-4] & st[31-26])
          | (st[31-5] & st[31-27]) | (st[31-6] & st[31-28]);
      v[31-2] = vx;
      v[31-1] = fex;
      return v;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      logic [31:0] v;
      v = view(model);
      check({tag, " rd_data"}, rd_data, v);
      check({"R9 ", tag, " round_mode"}, 32'(round_mode), 32'(v[1:0]));
      check({"R10 ", tag, " exc_req"}, 32'(exc_req), 32'(v[30]));
   endtask

   task automatic cyc(logic w, logic [31:0] wd, logic s, logic c,
                      logic [4:0] ix, logic r, logic [31:0] rm, string tag);
      wr_en = w; wr_data = wd; set_en = s; clr_en = c; bit_idx = ix;
      rpt_en = r; rpt_mask = rm;
      @(posedge clk);
      model = step_model(model, w, wd, s, c, ix, r, rm);
      #2;
      compare_all(tag);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 13;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset rd_data", rd_data, 32'h0);
      check("R1 reset round_mode", 32'(round_mode), 32'h0);
      check("R1 reset exc_req", 32'(exc_req), 32'h0);

      // R3/R8: set VXSNAN (arch 7) raises VX and FX
      cyc(0, 0, 1, 0, 5'd7, 0, 0, "R3 R8 set invalid flag");
      check("R3 VX on", 32'(rd_data[29]), 32'h1);
      check("R8 FX on", 32'(rd_data[31]), 32'h1);
      // R4: enable VE (arch 24) raises FEX
      cyc(0, 0, 1, 0, 5'd24, 0, 0, "R4 enable VE");
      check("R4 FEX on", 32'(rd_data[30]), 32'h1);
      // R5: commands on VX, FEX and reserved ignored
      cyc(0, 0, 0, 1, 5'd2, 0, 0, "R5 clear VX cmd");
      cyc(0, 0, 0, 1, 5'd1, 0, 0, "R5 clear FEX cmd");
      cyc(0, 0, 1, 0, 5'd20, 0, 0, "R5 set reserved");
      check("R5 reserved reads 0", 32'(rd_data[11]), 32'h0);
      // R11: clear the only invalid flag, VX and FEX drop together
      cyc(0, 0, 0, 1, 5'd7, 0, 0, "R11 clear last invalid");
      check("R11 VX off", 32'(rd_data[29]), 32'h0);
      check("R11 FEX off", 32'(rd_data[30]), 32'h0);
      // R8: clear FX, then set an already-set bit: FX stays 0
      cyc(0, 0, 1, 0, 5'd5, 0, 0, "R8 set ZX");
      cyc(0, 0, 0, 1, 5'd0, 0, 0, "R8 clear FX");
      cyc(0, 0, 1, 0, 5'd5, 0, 0, "R8 reset ZX no rise");
      check("R8 FX stays 0", 32'(rd_data[31]), 32'h0);
      // R2: set and clear together, set wins
      cyc(0, 0, 1, 1, 5'd29, 0, 0, "R2 set beats clear");
      // R6: write all ones, summaries recomputed, reserved 0
      cyc(1, 32'hFFFF_FFFF, 0, 0, 5'd0, 0, 0, "R6 write ones");
      cyc(1, 32'h6000_0000, 0, 0, 5'd0, 0, 0, "R6 write only summaries");
      check("R6 summaries ignored", rd_data, 32'h0);
      // R2: write beats set
      cyc(1, 32'h0000_0002, 1, 0, 5'd3, 0, 0, "R2 write beats set");
      // R9: rounding field
      cyc(1, 32'h0000_0003, 0, 0, 5'd0, 0, 0, "R9 round 3");
      check("R9 round_mode", 32'(round_mode), 32'h3);
      // R7: report ignores non-exception bits, comes after a clear
      cyc(0, 0, 0, 0, 5'd0, 1, 32'h8000_00FF, "R7 non-exception ignored");
      cyc(0, 0, 1, 0, 5'd3, 0, 0, "R7 set OX");
      cyc(0, 0, 0, 1, 5'd3, 1, 32'h1000_0000, "R7 clear then report OX");
      check("R7 OX kept", 32'(rd_data[28]), 32'h1);

      for (int i = 0; i < 3000; i++) begin
         logic w, s, c, r;
         logic [31:0] wd, rm;
         w  = ($urandom % 16) == 0;
         s  = ($urandom % 3) == 0;
         c  = ($urandom % 3) == 0;
         r  = ($urandom % 4) == 0;
         wd = $urandom;
         rm = $urandom & $urandom & $urandom;
         cyc(w, wd, s, c, 5'($urandom), r, rm, "R2 R3 R4 R7 R8 random");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule